// File: doc/BRIEF.md
# Scatter-Gather Packet Memory Endpoint

This block sits at the memory side of an interconnect. Request packets arrive on a 32-bit valid/ready stream, one chunk per cycle. Each packet is exactly seven chunks long: a header chunk followed by six body chunks. The header selects one of three request kinds, and the kind decides how the six body chunks are read.

A burst write body is a base address, a byte-mask chunk and four data words. The four words go to consecutive addresses. A gather body is six independent addresses. A scatter body is three address/data pairs, and every pair uses the single operation named in the header. The block performs each element access on its own local word memory, in the order the elements arrive.

Gathers and scatter read-modify-writes produce a reply packet on a second valid/ready stream. The reply is a transaction-ID chunk followed by the data words. While a reply is being sent, the request input is stalled. Malformed packets are swallowed whole and flagged.

The control is a five-state machine:
- HEAD waits for a header.
- A valid header moves it to BODY. A malformed header moves it to DROP.
- BODY and DROP each return to HEAD after the sixth body chunk. BODY instead moves to RID when the request expects a reply.
- RID presents the ID chunk and moves to RDAT once it is accepted.
- RDAT returns to HEAD when the last reply word is accepted.

Top module: `sgp_endpoint`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, err_o is 0, and every memory word reads as zero.
- R2: Header chunk layout: bits [1:0] are the kind (0 burst write, 1 gather, 2 scatter, 3 malformed), bits [4:2] are the operation, and bits [8:5] are the transaction ID. The operation field is ignored for burst and gather. Memory addresses are the low AW bits (6 by default) of an address chunk.
- R3: Burst write: data word k (k = 0..3) is written to base+k modulo the memory depth. Mask bit 4k+b enables byte b (bits 8b+7..8b) of word k. No reply is produced.
- R4: Gather: a reply carries the six words at the six addresses, in request order.
- R5: Scatter with operation 0 (store) writes each data word to its address and produces no reply.
- R6: Scatter read-modify-write with operation 1 add, 2 and, 3 or, 4 xor or 5 swap stores op(old, data) for each element. The reply carries the three old values in element order.
- R7: Elements are applied in order. An element that targets the address of an earlier element in the same packet sees that earlier element's result.
- R8: A reply chunk 0 has the ID in bits [3:0] and zeros elsewhere. out_last is 1 only on the final chunk. out_data and out_valid hold while out_ready is 0.
- R9: in_ready is 0 from the cycle after the last body chunk of a replying request until the last reply chunk is accepted.
- R10: A header of kind 3, or a scatter with operation 6 or 7, is malformed. All seven chunks are consumed, memory is unchanged, and no reply is produced. err_o is 1 for exactly the one cycle after the header handshake.
- R11: A chunk is taken only on a cycle with in_valid and in_ready both 1. Idle gaps between chunks do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request chunk valid |
| in_ready | output | 1 | Request chunk accepted when high with in_valid |
| in_data | input | 32 | Request chunk |
| out_valid | output | 1 | Reply chunk valid |
| out_ready | input | 1 | Reply sink ready |
| out_data | output | 32 | Reply chunk |
| out_last | output | 1 | Final chunk of a reply |
| err_o | output | 1 | One-cycle malformed-packet flag |

## Verification
Two functions can meet on the same memory word in back-to-back cycles. The write of one scatter element lands at a clock edge, and the read of the next element uses the same address in the following cycle. Likewise, a burst write is followed directly by a gather of those words. The bench provokes this with a scatter add that hits one address three times, and with gathers that come right after bursts. It judges the reply against a word-level model in which each element completes before the next begins, so a stale read shows up as a wrong old value. Reply backpressure is also checked against the input stall, because both are governed by the same reply states.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
    typedef enum logic [1:0] {
        PK_BURST   = 2'd0,
        PK_GATHER  = 2'd1,
        PK_SCATTER = 2'd2,
        PK_BAD     = 2'd3
    } pkt_kind_e;

    typedef enum logic [2:0] {
        OP_STORE = 3'd0,
        OP_ADD   = 3'd1,
        OP_AND   = 3'd2,
        OP_OR    = 3'd3,
        OP_XOR   = 3'd4,
        OP_SWAP  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } elem_op_e;

    typedef struct packed {
        logic [3:0] id;
        elem_op_e   op;
        pkt_kind_e  kind;
    } hdr_t;

    localparam int HDR_W     = $bits(hdr_t);
    localparam int BODY_LEN  = 6;
    localparam int REPLY_MAX = 6;
    localparam int SCAT_ELEM = 3;

    typedef enum logic [2:0] {
        ST_HEAD,
        ST_BODY,
        ST_DROP,
        ST_RID,
        ST_RDAT
    } sgp_state_e;
endpackage

// File: rtl/sgp_alu.sv
module sgp_alu
    import sgp_pkg::*;
#(
    parameter int DW = 32
) (
    input  elem_op_e        op,
    input  logic [DW-1:0]   old_val,
    input  logic [DW-1:0]   arg,
    output logic [DW-1:0]   result
);
    always_comb begin
        unique case (op)
            OP_ADD:  result = old_val + arg;
            OP_AND:  result = old_val & arg;
            OP_OR:   result = old_val | arg;
            OP_XOR:  result = old_val ^ arg;
            default: result = arg;
        endcase
    end
endmodule

// File: rtl/sgp_mem.sv
module sgp_mem #(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW/8-1:0]  wbe
);
    localparam int DEPTH = 1 << AW;
    localparam int NB    = DW / 8;

    logic [DW-1:0] words [DEPTH];

    assign rdata = words[raddr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (we) begin
            for (int b = 0; b < NB; b++) begin
                if (wbe[b]) begin
                    words[waddr][8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/sgp_endpoint.sv
module sgp_endpoint
    import sgp_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [DW-1:0]  in_data,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [DW-1:0]  out_data,
    output logic           out_last,
    output logic           err_o
);
    localparam int NB     = DW / 8;
    localparam int MASK_W = 4 * NB;

    sgp_state_e state, nxt;

    logic [2:0]        beat;
    pkt_kind_e         kind_q;
    elem_op_e          op_q;
    logic [3:0]        id_q;
    logic [AW-1:0]     base_q;
    logic [MASK_W-1:0] mask_q;
    logic [AW-1:0]     areg_q;
    logic [DW-1:0]     rbuf [REPLY_MAX];
    logic [2:0]        rcnt;
    logic [2:0]        ridx;
    logic              err_q;

    hdr_t hdr;
    logic fire, hdr_bad, body_end;
    logic reply_last;

    assign hdr      = hdr_t'(in_data[HDR_W-1:0]);
    assign fire     = in_valid && in_ready;
    assign hdr_bad  = (hdr.kind == PK_BAD) ||
                      ((hdr.kind == PK_SCATTER) &&
                       ((hdr.op == OP_RSV6) || (hdr.op == OP_RSV7)));
    assign body_end = fire && (beat == 3'(BODY_LEN - 1));

    // memory datapath
    logic [AW-1:0]  mem_raddr, mem_waddr;
    logic [DW-1:0]  mem_rdata, mem_wdata, alu_res;
    logic [NB-1:0]  mem_wbe;
    logic           mem_we;
    logic [1:0]     widx;
    logic           is_burst_wr, is_scat_data;

    assign widx         = beat[1:0] - 2'd2;
    assign is_burst_wr  = (state == ST_BODY) && fire && (kind_q == PK_BURST) && (beat >= 3'd2);
    assign is_scat_data = (state == ST_BODY) && fire && (kind_q == PK_SCATTER) && beat[0];

    assign mem_raddr = (kind_q == PK_GATHER) ? in_data[AW-1:0] : areg_q;
    assign mem_we    = is_burst_wr || is_scat_data;
    assign mem_waddr = (kind_q == PK_BURST) ? base_q + AW'(widx) : areg_q;
    assign mem_wdata = (kind_q == PK_BURST) ? in_data : alu_res;
    assign mem_wbe   = (kind_q == PK_BURST) ? mask_q[widx*NB +: NB] : '1;

    sgp_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (mem_raddr),
        .rdata (mem_rdata),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .wbe   (mem_wbe)
    );

    sgp_alu #(.DW(DW)) u_alu (
        .op      (op_q),
        .old_val (mem_rdata),
        .arg     (in_data),
        .result  (alu_res)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HEAD;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HEAD: if (fire) nxt = hdr_bad ? ST_DROP : ST_BODY;
            ST_BODY: if (body_end) nxt = (rcnt != 3'd0) ? ST_RID : ST_HEAD;
            ST_DROP: if (body_end) nxt = ST_HEAD;
            ST_RID:  if (out_ready) nxt = ST_RDAT;
            ST_RDAT: if (out_ready && reply_last) nxt = ST_HEAD;
            default: nxt = ST_HEAD;
        endcase
    end

    // outputs
    assign reply_last = (ridx == rcnt - 3'd1);

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        unique case (state)
            ST_HEAD, ST_BODY, ST_DROP: in_ready = 1'b1;
            ST_RID: begin
                out_valid = 1'b1;
                out_data  = DW'(id_q);
            end
            ST_RDAT: begin
                out_valid = 1'b1;
                out_data  = rbuf[ridx];
                out_last  = reply_last;
            end
            default: ;
        endcase
    end

    assign err_o = err_q;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat   <= '0;
            kind_q <= PK_BURST;
            op_q   <= OP_STORE;
            id_q   <= '0;
            base_q <= '0;
            mask_q <= '0;
            areg_q <= '0;
            rcnt   <= '0;
            ridx   <= '0;
            err_q  <= 1'b0;
            for (int i = 0; i < REPLY_MAX; i++) rbuf[i] <= '0;
        end else begin
            err_q <= (state == ST_HEAD) && fire && hdr_bad;
            if (state == ST_HEAD && fire) begin
                beat   <= '0;
                kind_q <= hdr.kind;
                op_q   <= hdr.op;
                id_q   <= hdr.id;
                if (hdr_bad)                                       rcnt <= 3'd0;
                else if (hdr.kind == PK_GATHER)                    rcnt <= 3'(REPLY_MAX);
                else if (hdr.kind == PK_SCATTER && hdr.op != OP_STORE) rcnt <= 3'(SCAT_ELEM);
                else                                               rcnt <= 3'd0;
            end
            if ((state == ST_BODY || state == ST_DROP) && fire) begin
                beat <= body_end ? 3'd0 : beat + 3'd1;
            end
            if (state == ST_BODY && fire) begin
                unique case (kind_q)
                    PK_BURST: begin
                        if (beat == 3'd0) base_q <= in_data[AW-1:0];
                        if (beat == 3'd1) mask_q <= in_data[MASK_W-1:0];
                    end
                    PK_GATHER: rbuf[beat] <= mem_rdata;
                    PK_SCATTER: begin
                        if (!beat[0]) areg_q <= in_data[AW-1:0];
                        else if (op_q != OP_STORE) rbuf[beat[2:1]] <= mem_rdata;
                    end
                    default: ;
                endcase
            end
            if (state == ST_RID && out_ready) ridx <= '0;
            if (state == ST_RDAT && out_ready) ridx <= ridx + 3'd1;
        end
    end

    // assertions
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    a_r8_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid);
    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);
    a_r4_reply_len: assert property (@(posedge clk) disable iff (!rst_n)
        rcnt <= 3'(REPLY_MAX));
endmodule

// File: tb/tb_sgp_endpoint.sv
module tb_sgp_endpoint;
    logic clk = 0, rst_n = 0;
    logic in_valid = 0, out_ready = 0;
    logic [31:0] in_data = '0;
    logic in_ready, out_valid, out_last, err_o;
    logic [31:0] out_data;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] m [64];

    always #2.5 clk = ~clk;

    sgp_endpoint dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr(input int kind, input int op, input int id);
        return {23'b0, 4'(id), 3'(op), 2'(kind)};
    endfunction

    function automatic logic [31:0] opf(input int op, input logic [31:0] o, input logic [31:0] d);
        case (op)
            1: return o + d;
            2: return o & d;
            3: return o | d;
            4: return o ^ d;
            default: return d;
        endcase
    endfunction

    task automatic put(input logic [31:0] d, input int gap);
        if (gap > 0) begin
            in_valid = 0;
            repeat (gap) @(negedge clk);
        end
        in_data = d;
        in_valid = 1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic send(input logic [31:0] h, input logic [31:0] b [6], input int gap);
        put(h, gap);
        for (int i = 0; i < 6; i++) put(b[i], gap);
    endtask

    task automatic get_reply(input int id, input int n, input logic [31:0] v [6], input bit stall, input string req);
        chk(in_ready == 0 && out_valid == 1, "R9", {31'b0, in_ready}, 32'h0);
        for (int k = 0; k <= n; k++) begin
            logic [31:0] e;
            e = (k == 0) ? 32'(id) : v[k-1];
            if (stall && k == 1) begin
                out_ready = 0;
                repeat (2) @(negedge clk);
                chk(out_valid && out_data == e, "R8 hold", out_data, e);
            end
            out_ready = 1;
            chk(out_valid && out_data == e, req, out_data, e);
            chk(out_last == (k == n), "R8 last", {31'b0, out_last}, {31'b0, k == n});
            @(negedge clk);
            out_ready = 0;
        end
        chk(out_valid == 0 && in_ready == 1, "R9 release", {31'b0, out_valid}, 32'h0);
    endtask

    task automatic gather(input int id, input logic [31:0] a [6], input bit stall, input string req);
        logic [31:0] v [6];
        for (int i = 0; i < 6; i++) v[i] = m[a[i][5:0]];
        send(hdr(1, 0, id), a, 0);
        get_reply(id, 6, v, stall, req);
    endtask

    task automatic burst(input logic [5:0] base, input logic [15:0] mask, input logic [31:0] d [4], input string req);
        logic [31:0] b [6];
        b[0] = {26'b0, base};
        b[1] = {16'b0, mask};
        for (int k = 0; k < 4; k++) begin
            b[k+2] = d[k];
            for (int j = 0; j < 4; j++)
                if (mask[4*k+j]) m[6'(base + 6'(k))][8*j +: 8] = d[k][8*j +: 8];
        end
        send(hdr(0, 5, 3), b, 0);
        chk(out_valid == 0 && in_ready == 1, req, {31'b0, out_valid}, 32'h0);
    endtask

    task automatic scatter(input int op, input int id, input logic [31:0] b [6], input int gap, input string req);
        logic [31:0] v [6];
        v = '{default: 0};
        for (int k = 0; k < 3; k++) begin
            v[k] = m[b[2*k][5:0]];
            m[b[2*k][5:0]] = opf(op, v[k], b[2*k+1]);
        end
        send(hdr(2, op, id), b, gap);
        if (op == 0) chk(out_valid == 0 && in_ready == 1, req, {31'b0, out_valid}, 32'h0);
        else get_reply(id, 3, v, 0, req);
    endtask

    task automatic t_reset;
        chk(in_ready == 1, "R1 in_ready", {31'b0, in_ready}, 32'h1);
        chk(out_valid == 0 && err_o == 0, "R1 outputs", {30'b0, out_valid, err_o}, 32'h0);
        gather(1, '{0, 7, 63, 20, 33, 1}, 0, "R1 zero memory");
    endtask

    task automatic t_burst;
        burst(6'd10, 16'hFFFF, '{32'hA0A0A0A0, 32'hB1B1B1B1, 32'hC2C2C2C2, 32'hD3D3D3D3}, "R3 no reply");
        gather(2, '{13, 10, 12, 11, 9, 14}, 0, "R3 R4 burst then gather");
        burst(6'd62, 16'hFFFF, '{32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444}, "R3 wrap");
        burst(6'd62, 16'hC01F, '{32'hAABBCCDD, 32'hEEFF0011, 32'h55667788, 32'h99887766}, "R3 mask");
        gather(3, '{62, 63, 0, 1, 32'hFFFF_FF3E, 2}, 1, "R3 R2 masked wrap");
    endtask

    task automatic t_scatter;
        scatter(0, 4, '{20, 32'h00000100, 21, 32'h0000FFFF, 22, 32'hF0F0F0F0}, 0, "R5 store");
        gather(5, '{20, 21, 22, 23, 20, 21}, 0, "R5 readback");
        scatter(1, 6, '{20, 32'h00000005, 21, 32'h00000001, 22, 32'h0F0F0F0F}, 0, "R6 add");
        scatter(2, 7, '{20, 32'h000000FF, 21, 32'h0000F0F0, 10, 32'hFFFF0000}, 0, "R6 and");
        scatter(3, 8, '{11, 32'h0000000F, 12, 32'h10000000, 13, 32'h00FF0000}, 0, "R6 or");
        scatter(4, 9, '{22, 32'hFFFFFFFF, 14, 32'h12345678, 0, 32'h0000FFFF}, 0, "R6 xor");
        scatter(5, 10, '{1, 32'hDEADBEEF, 2, 32'hCAFEF00D, 3, 32'h01020304}, 0, "R6 swap");
        gather(11, '{1, 2, 3, 22, 14, 0}, 0, "R6 readback");
    endtask

    task automatic t_raw;
        scatter(1, 12, '{40, 32'h00000010, 40, 32'h00000020, 40, 32'h00000300}, 0, "R7 chain add");
        scatter(5, 13, '{41, 32'h0000AAAA, 41, 32'h0000BBBB, 40, 32'h00000000}, 0, "R7 chain swap");
        gather(14, '{40, 41, 40, 41, 40, 41}, 0, "R7 readback");
    endtask

    task automatic t_bad;
        logic [31:0] b [6];
        b = '{5, 32'h77777777, 6, 32'h88888888, 7, 32'h99999999};
        put(hdr(3, 0, 2), 0);
        chk(err_o == 1, "R10 err raised", {31'b0, err_o}, 32'h1);
        put(b[0], 0);
        chk(err_o == 0, "R10 err one cycle", {31'b0, err_o}, 32'h0);
        for (int i = 1; i < 6; i++) put(b[i], 0);
        chk(out_valid == 0 && in_ready == 1, "R10 no reply", {31'b0, out_valid}, 32'h0);
        put(hdr(2, 6, 3), 0);
        chk(err_o == 1, "R10 bad op err", {31'b0, err_o}, 32'h1);
        for (int i = 0; i < 6; i++) put(b[i], 0);
        chk(out_valid == 0 && err_o == 0, "R10 bad op no reply", {30'b0, out_valid, err_o}, 32'h0);
        gather(15, '{5, 6, 7, 5, 6, 7}, 0, "R10 memory unchanged");
    endtask

    task automatic t_gaps;
        scatter(3, 0, '{50, 32'h00F00000, 51, 32'h00000A00, 50, 32'h0000000B}, 3, "R11 gaps");
        gather(1, '{50, 51, 52, 50, 51, 52}, 1, "R11 readback");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) m[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_burst();
        t_scatter();
        t_raw();
        t_bad();
        t_gaps();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule